// File: doc/BRIEF.md
# Direct-Mapped Four-Word-Line Cache

This block sits between a 32-bit processor and a slower memory. It holds 4096 lines, and each line carries a valid flag, a 16-bit tag and a four-word (128-bit) data block. A lookup is combinational. When the line is present and the tags agree, the requested word comes back in the same cycle with no stall. The processor presents an address together with a read or a write strobe. It holds them steady for as long as the stall output is high.

On a read miss the block controller asks memory for the whole 128-bit block. It installs the block when memory acknowledges, and the held access then hits on the following cycle. Writes go through to memory one word at a time. A write to an absent line first fills the line and then performs the word write. After reset, a sweep clears the valid flags one line per cycle while the processor is stalled.

Top module: `dmc_cache`

## Requirements
- R1: The address is split as tag = bits 31:16, line index = bits 15:4 and word select = bits 3:2. A lookup hits only if the indexed line is valid and its stored tag equals the address tag.
- R2: After reset is released, stall stays high for exactly 4096 cycles while every line is invalidated. The first access to any address after that misses.
- R3: A read that hits returns the selected word on cpu_rdata_o in the same cycle, with cpu_hit_o high and cpu_stall_o low.
- R4: A read miss raises stall and issues one memory request with mem_we_o = 0 at the block-aligned address (bits 3:0 zero). Word k of the block arrives in mem_rdata_i bits 32k+31:32k. The held read hits and returns the word in the cycle after the acknowledge.
- R5: Every write issues exactly one memory request with mem_we_o = 1, a word-aligned address (bits 1:0 zero) and mem_wdata_o equal to the write data. Stall stays high until the cycle in which mem_ack_i is high, and a later read of that address returns the written word.
- R6: A write to an absent line first performs a block fill and only then performs the word write.
- R7: Address bits 1:0 have no effect: every byte offset within a word reads the same word and hits or misses alike.
- R8: A fill replaces whatever the indexed line held, so an address with another tag at the same index misses afterwards.
- R9: While mem_req_o is high and mem_ack_i is low, mem_req_o, mem_addr_o and mem_we_o hold their values into the next cycle.
- R10: cpu_hit_o is low on any access whose line is absent, and any such access raises stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_addr_i | input | 32 | Processor byte address |
| cpu_rd_i | input | 1 | Read strobe, held while stalled |
| cpu_wr_i | input | 1 | Write strobe, held while stalled |
| cpu_wdata_i | input | 32 | Write data |
| cpu_rdata_o | output | 32 | Selected word of the indexed line |
| cpu_hit_o | output | 1 | Access hits a valid line with matching tag |
| cpu_stall_o | output | 1 | Processor must hold its access |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = word write, 0 = block read |
| mem_addr_o | output | 32 | Block-aligned (read) or word-aligned (write) address |
| mem_wdata_o | output | 32 | Word written to memory |
| mem_rdata_i | input | 128 | Block returned by memory |
| mem_ack_i | input | 1 | Memory completes the transfer this cycle |

## Verification
The bound checker watches the memory handshake on every cycle. It checks that a pending request keeps its address and direction, that fill and write addresses are aligned, that write data follows the processor, and that a miss always raises stall. It also checks that stall covers the whole clearing sweep and that a completed fill turns into a hit. Only the bench scenarios can show that data survives end to end. They show that read data matches what memory holds after earlier write-throughs, that a conflicting tag evicts a line, that a write miss fills before it writes, and that a second reset forgets every line.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_IDLE  = 2'd1,
    ST_FILL  = 2'd2,
    ST_WRITE = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int INDEX_W = 12,
  parameter int TAG_W   = 16
) (
  input  logic               clk_i,
  input  logic [INDEX_W-1:0] idx_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic               clr_en_i,
  input  logic [INDEX_W-1:0] clr_idx_i,
  input  logic               fill_en_i,
  output logic               match_o
);
  localparam int LINES = 1 << INDEX_W;

  logic             valid_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  // valid array is initialised by the sweep, not by reset
  always_ff @(posedge clk_i) begin
    if (clr_en_i) begin
      valid_q[clr_idx_i] <= 1'b0;
    end else if (fill_en_i) begin
      valid_q[idx_i] <= 1'b1;
      tag_q[idx_i]   <= tag_i;
    end
  end

  assign match_o = valid_q[idx_i] && (tag_q[idx_i] == tag_i);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int INDEX_W = 12,
  parameter int WORD_W  = 32,
  parameter int WSEL_W  = 2
) (
  input  logic                       clk_i,
  input  logic [INDEX_W-1:0]         idx_i,
  input  logic [WSEL_W-1:0]          wsel_i,
  input  logic                       fill_en_i,
  input  logic [WORD_W*(1<<WSEL_W)-1:0] fill_line_i,
  input  logic                       word_en_i,
  input  logic [WORD_W-1:0]          word_i,
  output logic [WORD_W-1:0]          word_o
);
  localparam int LINES = 1 << INDEX_W;
  localparam int WORDS = 1 << WSEL_W;

  logic [WORD_W-1:0] rd_words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_bank
    logic [WORD_W-1:0] bank_q [LINES];
    logic              sel_w;

    assign sel_w = word_en_i && (wsel_i == WSEL_W'(g));

    always_ff @(posedge clk_i) begin
      if (fill_en_i) begin
        bank_q[idx_i] <= fill_line_i[g*WORD_W +: WORD_W];
      end else if (sel_w) begin
        bank_q[idx_i] <= word_i;
      end
    end

    assign rd_words[g] = bank_q[idx_i];
  end

  assign word_o = rd_words[wsel_i];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int INDEX_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic               match_i,
  input  logic               mem_ack_i,
  output logic               lookup_en_o,
  output logic               stall_o,
  output logic               clr_en_o,
  output logic [INDEX_W-1:0] clr_idx_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic               fill_en_o,
  output logic               word_en_o
);
  localparam logic [INDEX_W-1:0] LAST_IDX = {INDEX_W{1'b1}};

  dmc_state_e         state_q, state_d;
  logic [INDEX_W-1:0] clr_q, clr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CLEAR;
      clr_q   <= '0;
    end else begin
      state_q <= state_d;
      clr_q   <= clr_d;
    end
  end

  always_comb begin
    state_d   = state_q;
    clr_d     = clr_q;
    stall_o   = 1'b0;
    clr_en_o  = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    fill_en_o = 1'b0;
    word_en_o = 1'b0;
    unique case (state_q)
      ST_CLEAR: begin
        stall_o  = 1'b1;
        clr_en_o = 1'b1;
        clr_d    = clr_q + 1'b1;
        if (clr_q == LAST_IDX) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if ((rd_i || wr_i) && !match_i) begin
          stall_o = 1'b1;
          state_d = ST_FILL;
        end else if (wr_i) begin
          stall_o = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_FILL: begin
        stall_o   = 1'b1;
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          fill_en_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_WRITE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        stall_o   = !mem_ack_i;
        if (mem_ack_i) begin
          word_en_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_CLEAR;
    endcase
  end

  assign clr_idx_o   = clr_q;
  assign lookup_en_o = (state_q != ST_CLEAR);
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int INDEX_W = 12,
  parameter int WSEL_W  = 2,
  parameter int BSEL_W  = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              cpu_addr_i,
  input  logic                           cpu_rd_i,
  input  logic                           cpu_wr_i,
  input  logic [WORD_W-1:0]              cpu_wdata_i,
  output logic [WORD_W-1:0]              cpu_rdata_o,
  output logic                           cpu_hit_o,
  output logic                           cpu_stall_o,
  output logic                           mem_req_o,
  output logic                           mem_we_o,
  output logic [ADDR_W-1:0]              mem_addr_o,
  output logic [WORD_W-1:0]              mem_wdata_o,
  input  logic [WORD_W*(1<<WSEL_W)-1:0]  mem_rdata_i,
  input  logic                           mem_ack_i
);
  localparam int OFFS_W = WSEL_W + BSEL_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - OFFS_W;

  logic [TAG_W-1:0]   tag_w;
  logic [INDEX_W-1:0] idx_w;
  logic [WSEL_W-1:0]  wsel_w;
  logic [BSEL_W-1:0]  unused_byte_sel;

  assign tag_w           = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign idx_w           = cpu_addr_i[OFFS_W +: INDEX_W];
  assign wsel_w          = cpu_addr_i[BSEL_W +: WSEL_W];
  assign unused_byte_sel = cpu_addr_i[BSEL_W-1:0];

  logic               match_w, lookup_en_w;
  logic               clr_en_w, fill_en_w, word_en_w;
  logic [INDEX_W-1:0] clr_idx_w;

  dmc_tag_store #(
    .INDEX_W (INDEX_W),
    .TAG_W   (TAG_W)
  ) i_tags (
    .clk_i     (clk_i),
    .idx_i     (idx_w),
    .tag_i     (tag_w),
    .clr_en_i  (clr_en_w),
    .clr_idx_i (clr_idx_w),
    .fill_en_i (fill_en_w),
    .match_o   (match_w)
  );

  dmc_data_store #(
    .INDEX_W (INDEX_W),
    .WORD_W  (WORD_W),
    .WSEL_W  (WSEL_W)
  ) i_data (
    .clk_i       (clk_i),
    .idx_i       (idx_w),
    .wsel_i      (wsel_w),
    .fill_en_i   (fill_en_w),
    .fill_line_i (mem_rdata_i),
    .word_en_i   (word_en_w),
    .word_i      (cpu_wdata_i),
    .word_o      (cpu_rdata_o)
  );

  dmc_ctrl #(
    .INDEX_W (INDEX_W)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (cpu_rd_i),
    .wr_i        (cpu_wr_i),
    .match_i     (match_w),
    .mem_ack_i   (mem_ack_i),
    .lookup_en_o (lookup_en_w),
    .stall_o     (cpu_stall_o),
    .clr_en_o    (clr_en_w),
    .clr_idx_o   (clr_idx_w),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .fill_en_o   (fill_en_w),
    .word_en_o   (word_en_w)
  );

  assign cpu_hit_o   = lookup_en_w && match_w && (cpu_rd_i || cpu_wr_i);
  assign mem_wdata_o = cpu_wdata_i;
  assign mem_addr_o  = mem_we_o ? {cpu_addr_i[ADDR_W-1:BSEL_W], {BSEL_W{1'b0}}}
                                : {cpu_addr_i[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int INDEX_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_rd_i,
  input logic              cpu_wr_i,
  input logic [WORD_W-1:0] cpu_wdata_i,
  input logic              cpu_hit_o,
  input logic              cpu_stall_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  localparam logic [INDEX_W:0] LINES_C = {1'b1, {INDEX_W{1'b0}}};

  logic [INDEX_W:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_rst_q <= '0;
    else if (since_rst_q < LINES_C) since_rst_q <= since_rst_q + 1'b1;
  end

  p_sweep_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q < LINES_C) |-> cpu_stall_o);

  p_miss_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpu_rd_i || cpu_wr_i) && !cpu_hit_o) |-> cpu_stall_o);

  p_hit_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && !cpu_wr_i && cpu_hit_o) |-> !cpu_stall_o);

  p_fill_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o[3:0] == 4'd0));

  p_fill_hits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i && cpu_rd_i && !cpu_wr_i) |=> cpu_hit_o);

  p_write_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o[1:0] == 2'd0 && mem_wdata_o == cpu_wdata_i
                                 && mem_addr_o[ADDR_W-1:2] == cpu_addr_i[ADDR_W-1:2]));

  p_write_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ack_i) |-> cpu_stall_o);

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

bind dmc_cache dmc_cache_chk #(
  .ADDR_W  (ADDR_W),
  .WORD_W  (WORD_W),
  .INDEX_W (INDEX_W)
) i_dmc_cache_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_rd_i    (cpu_rd_i),
  .cpu_wr_i    (cpu_wr_i),
  .cpu_wdata_i (cpu_wdata_i),
  .cpu_hit_o   (cpu_hit_o),
  .cpu_stall_o (cpu_stall_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/test_dmc_cache.sv
`timescale 1ns/1ps
module test_dmc_cache;
  localparam int LINES = 4096;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic         cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_hit, cpu_stall;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr, mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ack = 1'b0;

  always #5 clk = ~clk;

  dmc_cache i_dmc_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_addr_i(cpu_addr), .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .cpu_hit_o(cpu_hit), .cpu_stall_o(cpu_stall),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] mem_m [logic [29:0]];
  logic [15:0] btag [int];
  int n_fill = 0, n_wr = 0, seq = 0, fill_seq = 0, wr_seq = 0;
  logic [31:0] last_fill_addr, last_wr_addr, last_wr_data;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (mem_m.exists(a[31:2])) return mem_m[a[31:2]];
    return ({2'b00, a[31:2]} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [127:0] mem_block(input logic [31:0] a);
    logic [127:0] b;
    for (int k = 0; k < 4; k++) b[32*k +: 32] = mem_word({a[31:4], 2'(k), 2'b00});
    return b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    int dly = 0;
    bit pend = 0;
    logic [31:0] req_addr = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (rst_n && mem_req) begin
        if (!pend) begin pend = 1; req_addr = mem_addr; end
        if (dly == 0) begin
          chk("R9 request address held", mem_addr, req_addr);
          seq++;
          if (mem_we) begin
            mem_m[mem_addr[31:2]] = mem_wdata;
            n_wr++; wr_seq = seq;
            last_wr_addr = mem_addr; last_wr_data = mem_wdata;
          end else begin
            mem_rdata = mem_block(mem_addr);
            n_fill++; fill_seq = seq;
            last_fill_addr = mem_addr;
          end
          mem_ack = 1'b1;
          pend = 0;
          dly = int'($urandom % 3);
        end else dly--;
      end
    end
  end

  task automatic cpu_access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                            output bit f_hit, output bit f_stall, output logic [31:0] rdata);
    @(negedge clk);
    cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = d;
    #1;
    f_hit = cpu_hit; f_stall = cpu_stall;
    while (cpu_stall) begin
      @(negedge clk); #1;
    end
    rdata = cpu_rdata;
    if (!wr) chk("R4 hit at completion", 32'(cpu_hit), 32'd1);
    @(posedge clk); #1;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic do_access(input bit wr, input logic [31:0] a, input logic [31:0] d);
    bit exp_hit, f_hit, f_stall;
    logic [31:0] rdata;
    int nf0 = n_fill, nw0 = n_wr;
    int idx = int'(a[15:4]);
    exp_hit = btag.exists(idx) && (btag[idx] == a[31:16]);
    cpu_access(wr, a, d, f_hit, f_stall, rdata);
    chk("R1/R8/R10 hit flag", 32'(f_hit), 32'(exp_hit));
    if (!exp_hit) begin
      chk("R10 miss stalls", 32'(f_stall), 32'd1);
      chk("R4 one fill per miss", 32'(n_fill - nf0), 32'd1);
      chk("R4 fill address aligned", last_fill_addr, {a[31:4], 4'h0});
    end else begin
      chk("R3 no fill on hit", 32'(n_fill - nf0), 32'd0);
    end
    if (wr) begin
      chk("R5 write stalls", 32'(f_stall), 32'd1);
      chk("R5 one memory write", 32'(n_wr - nw0), 32'd1);
      chk("R5 write address", last_wr_addr, {a[31:2], 2'b00});
      chk("R5 write data", last_wr_data, d);
      if (!exp_hit) chk("R6 fill before write", 32'(fill_seq < wr_seq), 32'd1);
    end else begin
      if (exp_hit) chk("R3 hit without stall", 32'(f_stall), 32'd0);
      chk("R3/R4/R7 read data", rdata, mem_word(a));
      chk("R3 no write on read", 32'(n_wr - nw0), 32'd0);
    end
    btag[idx] = a[31:16];
  endtask

  task automatic do_reset();
    int cnt = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 stall in reset", 32'(cpu_stall), 32'd1);
    chk("R2 no request in reset", 32'(mem_req), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    while (cpu_stall && cnt < 3 * LINES) begin
      cnt++;
      @(negedge clk); #1;
    end
    chk("R2 clearing sweep length", 32'(cnt), 32'(LINES));
    btag.delete();
  endtask

  localparam logic [31:0] A = 32'h0003_0128;
  localparam logic [31:0] B = 32'h0007_0128;

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // directed corner cases
    do_access(0, A, '0);                    // R4 cold miss
    do_access(0, A, '0);                    // R3 hit
    do_access(0, A | 32'h1, '0);            // R7 byte offset 1
    do_access(0, A | 32'h3, '0);            // R7 byte offset 3
    do_access(0, A + 32'h4, '0);            // R1 other word same line
    do_access(1, A + 32'h4, 32'hCAFE_0001); // R5 write hit
    do_access(0, A + 32'h6, '0);            // R5/R7 read back
    do_access(0, B, '0);                    // R8 conflict evicts A
    do_access(0, A, '0);                    // R8 A misses again
    do_access(1, 32'h0010_0FF0, 32'h1234_5678); // R6 write miss
    do_access(0, 32'h0010_0FF0, '0);        // R6 merged word kept
    do_access(0, 32'h0010_0FF4, '0);        // R6 rest of block from memory
    do_access(0, 32'hFFFF_FFFC, '0);        // R1 top index, top word
    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a;
      a = {14'd0, 2'($urandom % 3), 1'($urandom % 2), 7'd0,
           4'($urandom % 8), 2'($urandom % 4), 2'($urandom % 4)};
      do_access(($urandom % 3) == 0, a, $urandom);
    end
    // R2 second reset forgets all lines
    do_reset();
    do_access(0, A, '0);
    do_access(0, A, '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule